// File: doc/BRIEF.md
# Burst-of-four quad-data-rate SRAM model

This block is a synthesizable behavioural model of a quad-data-rate static RAM. It has an independent read port and write port that share one address bus. Every access moves a fixed burst of four data words at double data rate. The two edges of the device input clock are represented by a single fast clock `clk`. The block keeps an internal half-cycle flag, `k_phase`, and exports it. A cycle with `k_phase` = 0 is the first half of a K period (the K rising edge). A cycle with `k_phase` = 1 is the second half (the K# rising edge). Commands are taken only in first-half cycles. Data beats move in every cycle.

The storage is split into four banks, one per beat position. All four beats of a burst use the same word address, and beat k always lives in bank k. With the default `AW` = 4 each bank holds 16 words. Setting `AW` to 17 with the default 36-bit word gives four banks of 128K words. The two ports run concurrently. A read that overlaps a write to the same address returns new data only for beats that were stored before that read beat was fetched. `rvalid` with a zero data bus stands in for a high-impedance output.

Top module: `qdr_b4_sram`

## Requirements
- R1: During reset and in the first cycle after the last reset edge, `k_phase` is 0, `rvalid` is 0 and `rdata` is 0. After that, `k_phase` inverts on every clock.
- R2: When `wr_sel_n` is low in a cycle t with `k_phase` = 0 and the write port accepts it, `addr` is captured. The `wdata` values presented in cycles t+2, t+3, t+4 and t+5 become beats 0, 1, 2 and 3 stored at that address.
- R3: `wbyte_n` is sampled in the same cycle as each write beat and is active low. Bit i covers `wdata[9i+8:9i]`. A byte whose bit is 1 keeps its previous contents.
- R4: When `rd_sel_n` is low in a cycle t with `k_phase` = 0 and the read port is idle, beats 0 to 3 of the stored word at `addr` appear on `rdata` in cycles t+2 to t+5, with `rvalid` at 1.
- R5: Whenever `rvalid` is 0, `rdata` is 0. If no further read is pending, `rvalid` falls in the cycle right after beat 3, even when `rd_sel_n` was released before the burst ended.
- R6: A read command accepted while a burst is on the output is held in one pending slot. Its beat 0 follows the current beat 3 in the very next cycle, with no gap and no repeated beat.
- R7: A read command seen while the pending slot is already occupied is ignored.
- R8: A write command that arrives in the cycle carrying beat 0 of an ongoing write burst is ignored. A write command that arrives in the cycle carrying beat 2 is accepted, and its beats follow beat 3 without a gap.
- R9: For a read and a write to the same address, a read command one K period after the write command returns all four newly written beats. A read command in the same cycle as the write command returns all four old beats.
- R10: `rd_sel_n` and `wr_sel_n` are ignored in cycles with `k_phase` = 1. No burst starts and no storage changes as a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two cycles per K period |
| rst | input | 1 | Synchronous active-high reset |
| k_phase | output | 1 | 0 in the first half of a K period, 1 in the second half |
| rd_sel_n | input | 1 | Read command, active low, taken when `k_phase` = 0 |
| wr_sel_n | input | 1 | Write command, active low, taken when `k_phase` = 0 |
| addr | input | AW | Shared word address for both ports |
| wdata | input | DW | Write data beat |
| wbyte_n | input | NBYTES | Active-low byte enables for the current write beat |
| rdata | output | DW | Read data beat, zero when not valid |
| rvalid | output | 1 | Read output enable, stands in for driving the bus |

## Verification
The hardest cases to reach are the ones where the two ports and the pending slots interact in a particular half-cycle. These are a write command landing on beat 0 or beat 2 of a running write, a third read while one read is active and one is pending, and a read scheduled against a write to the same address one K period apart. The bench drives these with per-cycle stimulus tables aligned to `k_phase` = 0, so each command lands in an exact half-cycle. Expected outputs come from a bench-side memory image that is updated from the requirements. For the same-cycle overlap case, the expected beats are taken from that image before it is updated.

// File: rtl/qdr_b4_pkg.sv
package qdr_b4_pkg;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);
  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/qdr_b4_bank.sv
module qdr_b4_bank #(
  parameter int AW     = 4,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [NBYTES-1:0]        wbe,
  input  logic [AW-1:0]            waddr,
  input  logic [BYTE_W*NBYTES-1:0] wdata,
  input  logic [AW-1:0]            raddr,
  output logic [BYTE_W*NBYTES-1:0] rq
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = BYTE_W * NBYTES;

  logic [DW-1:0] mem [DEPTH];

  // byte-masked write port
  always_ff @(posedge clk) begin
    for (int i = 0; i < NBYTES; i++) begin
      if (we && wbe[i]) mem[waddr][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
    end
  end

  // asynchronous read; the output register lives in the read controller
  assign rq = mem[raddr];
endmodule

// File: rtl/qdr_b4_wr_ctrl.sv
module qdr_b4_wr_ctrl
  import qdr_b4_pkg::*;
#(
  parameter int AW     = 4,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_phase,
  input  logic              wr_sel_n,
  input  logic [AW-1:0]     addr,
  input  logic [NBYTES-1:0] wbyte_n,
  output logic [BEATS-1:0]  bank_we,
  output logic [NBYTES-1:0] wbe,
  output logic [AW-1:0]     waddr
);
  logic          pend_q, act_q;
  logic [AW-1:0] pend_addr_q, addr_q;
  beat_t         beat_q;
  logic          accept;

  // a new command may overlap only the second K period of a running burst
  assign accept = !k_phase && !wr_sel_n && (!act_q || beat_q == beat_t'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      act_q       <= 1'b0;
      beat_q      <= '0;
      pend_addr_q <= '0;
      addr_q      <= '0;
    end else begin
      if (accept) begin
        pend_q      <= 1'b1;
        pend_addr_q <= addr;
      end
      if (k_phase && pend_q) begin
        act_q  <= 1'b1;
        addr_q <= pend_addr_q;
        beat_q <= '0;
        pend_q <= 1'b0;
      end else if (act_q) begin
        if (beat_q == beat_t'(BEATS-1)) act_q <= 1'b0;
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BEATS; b++) bank_we[b] = act_q && (beat_q == beat_t'(b));
  end

  assign wbe   = ~wbyte_n;
  assign waddr = addr_q;
endmodule

// File: rtl/qdr_b4_rd_ctrl.sv
module qdr_b4_rd_ctrl
  import qdr_b4_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          k_phase,
  input  logic          rd_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bank_word,
  output beat_t         sel_bank,
  output logic [AW-1:0] sel_addr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          pend_q;
  logic [AW-1:0] pend_addr_q, cur_addr_q;
  beat_t         beat_q;
  logic          accept, launch, advance, drive;

  assign accept  = !k_phase && !rd_sel_n && !pend_q;
  assign launch  = k_phase && pend_q && (!rvalid || beat_q == beat_t'(BEATS-1));
  assign advance = rvalid && (!k_phase || beat_q == beat_t'(1));
  assign drive   = launch || advance;

  assign sel_bank = launch ? beat_t'(0) : beat_q + 1'b1;
  assign sel_addr = launch ? pend_addr_q : cur_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      cur_addr_q  <= '0;
      beat_q      <= '0;
      rvalid      <= 1'b0;
      rdata       <= '0;
    end else begin
      if (accept) begin
        pend_q      <= 1'b1;
        pend_addr_q <= addr;
      end
      if (launch) begin
        pend_q     <= 1'b0;
        cur_addr_q <= pend_addr_q;
      end
      if (drive) beat_q <= sel_bank;
      rvalid <= drive;
      rdata  <= drive ? bank_word : '0;
    end
  end
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram
  import qdr_b4_pkg::*;
#(
  parameter int AW     = 4,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  parameter int DW     = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  output logic              k_phase,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NBYTES-1:0] wbyte_n,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);
  logic [BEATS-1:0]  bank_we;
  logic [NBYTES-1:0] wbe;
  logic [AW-1:0]     waddr, raddr;
  beat_t             rbank;
  logic [DW-1:0]     bank_q [BEATS];

  always_ff @(posedge clk) begin
    if (rst) k_phase <= 1'b0;
    else     k_phase <= ~k_phase;
  end

  qdr_b4_wr_ctrl #(.AW(AW), .NBYTES(NBYTES)) u_wr (
    .clk(clk), .rst(rst), .k_phase(k_phase), .wr_sel_n(wr_sel_n), .addr(addr),
    .wbyte_n(wbyte_n), .bank_we(bank_we), .wbe(wbe), .waddr(waddr)
  );

  generate
    for (genvar b = 0; b < BEATS; b++) begin : g_bank
      qdr_b4_bank #(.AW(AW), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_bank (
        .clk(clk), .we(bank_we[b]), .wbe(wbe), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rq(bank_q[b])
      );
    end
  endgenerate

  qdr_b4_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .k_phase(k_phase), .rd_sel_n(rd_sel_n), .addr(addr),
    .bank_word(bank_q[rbank]), .sel_bank(rbank), .sel_addr(raddr),
    .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          k_phase,
  input logic          rd_sel_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (k_phase != $past(k_phase)));                       // R1
  AST_BURST_START_HALF: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> !k_phase);                                        // R4
  AST_BURST_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> ($past(!rd_sel_n, 2) && $past(!k_phase, 2)));     // R4
  AST_BURST_END_HALF: assert property (@(posedge clk) disable iff (rst)
    $fell(rvalid) |-> !k_phase);                                        // R5
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));                                         // R5
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .k_phase(k_phase), .rd_sel_n(rd_sel_n),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/qdr_b4_sram_test.sv
module qdr_b4_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, BW = 9, NB = 4, DW = BW * NB, NCYC = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] wbyte_n = '1;
  logic k_phase, rvalid;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0, phase_bad = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [4][1<<AW];
  logic          s_rs [NCYC], s_ws [NCYC];
  logic [AW-1:0] s_a  [NCYC];
  logic [DW-1:0] s_d  [NCYC];
  logic [NB-1:0] s_be [NCYC];
  bit            e_chk [NCYC];
  logic          e_v  [NCYC];
  logic [DW-1:0] e_d  [NCYC];
  string         e_tag[NCYC];

  qdr_b4_sram #(.AW(AW), .BYTE_W(BW), .NBYTES(NB)) uut (
    .clk(clk), .rst(rst), .k_phase(k_phase), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .wbyte_n(wbyte_n), .rdata(rdata), .rvalid(rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mkw(int a, int k, int seed);
    return {4'(k + 1), 8'(a), 24'(seed * 24'h010203 + k * 24'h001234)};
  endfunction

  task automatic check(string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_seq();
    for (int i = 0; i < NCYC; i++) begin
      s_rs[i] = 1'b1; s_ws[i] = 1'b1; s_a[i] = '0; s_d[i] = '0; s_be[i] = '1;
      e_chk[i] = 0; e_v[i] = 1'b0; e_d[i] = '0; e_tag[i] = "";
    end
  endtask

  task automatic plan_wr(int c, int a, int seed, logic [4*NB-1:0] bes);
    s_ws[c] = 1'b0; s_a[c] = AW'(a);
    for (int k = 0; k < 4; k++) begin
      s_d[c+2+k] = mkw(a, k, seed); s_be[c+2+k] = bes[k*NB +: NB];
    end
  endtask

  task automatic ref_wr(int a, int seed, logic [4*NB-1:0] bes);
    for (int k = 0; k < 4; k++)
      for (int by = 0; by < NB; by++)
        if (!bes[k*NB+by]) ref_mem[k][a][by*BW +: BW] = mkw(a, k, seed)[by*BW +: BW];
  endtask

  task automatic plan_rd(int c, int a);
    s_rs[c] = 1'b0; s_a[c] = AW'(a);
  endtask

  task automatic exp_burst(int c, int a, string tag);
    for (int k = 0; k < 4; k++) begin
      e_chk[c+k] = 1; e_v[c+k] = 1'b1; e_d[c+k] = ref_mem[k][a]; e_tag[c+k] = tag;
    end
  endtask

  task automatic exp_idle(int c, string tag);
    e_chk[c] = 1; e_v[c] = 1'b0; e_d[c] = '0; e_tag[c] = tag;
  endtask

  // cycle 0 of the table is a cycle with k_phase = 0; checks then drives at each negedge
  task automatic run_seq(int n);
    @(negedge clk);
    while (k_phase !== 1'b0) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (k_phase !== 1'(i % 2)) phase_bad++;
      if (e_chk[i]) check($sformatf("%s cycle %0d", e_tag[i], i), {rvalid, rdata}, {e_v[i], e_d[i]});
      rd_sel_n = s_rs[i]; wr_sel_n = s_ws[i]; addr = s_a[i]; wdata = s_d[i]; wbyte_n = s_be[i];
    end
    @(negedge clk);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; wbyte_n = '1;
  endtask

  task automatic do_write(int a, int seed, logic [4*NB-1:0] bes);
    clear_seq(); plan_wr(0, a, seed, bes); ref_wr(a, seed, bes); run_seq(7);
  endtask

  task automatic do_read(int a, string tag);
    clear_seq(); plan_rd(0, a); exp_idle(1, tag); exp_burst(2, a, tag); exp_idle(6, tag); run_seq(8);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 reset state", {k_phase, rvalid, rdata}, '0);
    rst = 1'b0;
  endtask

  task automatic t_basic();
    do_write(3, 1, '0);                                     // R2 full write
    do_read(3, "R2 R4 R5 basic");
  endtask

  task automatic t_mask();
    do_write(3, 2, {4'b0000, 4'b0101, 4'b1010, 4'b1110});   // R3 per-beat masks
    do_read(3, "R3 byte mask");
  endtask

  task automatic t_read_queue();
    do_write(5, 3, '0); do_write(6, 4, '0); do_write(7, 5, '0);
    clear_seq();
    plan_rd(0, 5); plan_rd(2, 6); plan_rd(4, 7);
    exp_burst(2, 5, "R6 first");
    exp_burst(6, 6, "R6 queued");
    exp_idle(10, "R7 third read ignored"); exp_idle(11, "R7 third read ignored");
    run_seq(13);
  endtask

  task automatic t_write_overlap();
    do_write(9, 6, '0);
    clear_seq();
    plan_wr(0, 8, 7, '0);
    s_ws[2] = 1'b0; s_a[2] = AW'(9);                        // R8 lands on beat 0: ignored
    plan_wr(4, 10, 8, '0);                                  // R8 lands on beat 2: accepted
    ref_wr(8, 7, '0); ref_wr(10, 8, '0);
    run_seq(11);
    clear_seq();
    plan_rd(0, 9); plan_rd(4, 8); plan_rd(8, 10);
    exp_burst(2, 9, "R8 ignored write");
    exp_burst(6, 8, "R8 first write");
    exp_burst(10, 10, "R8 chained write");
    exp_idle(14, "R8 end");
    run_seq(16);
  endtask

  task automatic t_odd_half();
    do_write(12, 9, '0);
    clear_seq();
    s_rs[1] = 1'b0; s_ws[1] = 1'b0; s_a[1] = AW'(12);
    for (int i = 1; i < 7; i++) begin
      s_d[i] = '1; s_be[i] = '0; exp_idle(i, "R10 second-half select");
    end
    run_seq(8);
    do_read(12, "R10 storage unchanged");
  endtask

  task automatic t_coherency();
    do_write(14, 10, '0);
    clear_seq();
    plan_wr(0, 14, 11, '0); plan_rd(2, 14);
    ref_wr(14, 11, '0);
    exp_burst(4, 14, "R9 read one K later sees new");
    run_seq(9);
    clear_seq();
    plan_wr(0, 14, 12, '0); plan_rd(0, 14);
    exp_burst(2, 14, "R9 same K read sees old");
    ref_wr(14, 12, '0);
    run_seq(7);
    do_read(14, "R9 write completed");
  endtask

  initial begin
    repeat (200 * NCYC * 20) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_mask();
    t_read_queue();
    t_write_overlap();
    t_odd_half();
    t_coherency();
    check("R1 phase alternation", 33'(phase_bad), 33'(0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule